// File: doc/BRIEF.md
# Receiver Error Status Latch and Interrupt

This block collects four per-event conditions reported by a digital audio receiver: received validity bit high, parity error, biphase coding violation and loss of lock. Each arrives as a single-clock pulse and is held in a sticky bit until the host reads the register that holds it. A host-writable mask picks which conditions may drive an error pin. The pin pulses once for every enabled occurrence.

Each error-pin pulse also sets a summary flag. The summary flag raises a host interrupt only when it goes from clear to set while the summary interrupt enable is on. Repeated errors leave the interrupt as it is until the host reads the summary register. The summary flag is held by a three-state machine. `FLAG_CLEAR` means no flag. `FLAG_RAISED` means the flag is set and an interrupt is pending. `FLAG_HELD` means the flag is set and no interrupt was raised.

The machine moves as follows. From `FLAG_CLEAR`, an enabled hit goes to `FLAG_RAISED` when the interrupt enable is on, and to `FLAG_HELD` when it is off. From `FLAG_RAISED` or `FLAG_HELD`, a summary read with no hit goes back to `FLAG_CLEAR`. A summary read that coincides with a hit is treated as a fresh occurrence: it goes to `FLAG_RAISED` or `FLAG_HELD` according to the enable. Any other hit leaves the state unchanged.

Top module: `rx_error_status`

## Requirements
- R1: After reset, all sticky bits, both enable registers, the summary flag, `err_flag_o` and `irq_o` are zero.
- R2: A pulse on `cond_evt[i]` sets sticky bit i of the condition status register (address 2) whatever the mask says. Bit 0 is validity, bit 1 parity, bit 2 coding violation and bit 3 out-of-lock. Bit 4 reads 0, and bits 7:5 show `freq_code`.
- R3: A read of address 2 returns the value held before the read, and its sticky bits are zero from the next clock.
- R4: A condition pulse in the same cycle as a read of address 2 leaves its bit set after the read.
- R5: The condition mask (address 3) stores write bits 3:0, one per condition in the R2 order. Bits 7:4 always read 0.
- R6: `err_flag_o` is high for exactly the one clock after each cycle in which any condition pulses with its mask bit at 1. This holds for every occurrence. A masked condition produces no pulse.
- R7: The summary status register (address 0) shows the summary flag in bit 3, and its other bits read 0. Every `err_flag_o` pulse coincides with the flag being set.
- R8: `irq_o` rises on the clock after a hit only when the flag was clear and summary enable bit 3 (address 1) was 1. A hit while the flag is already set never raises `irq_o`, even if the enable has since been turned on.
- R9: A read of address 0 returns the pre-read value and clears the flag and `irq_o` on the next clock. A hit in the same cycle wins: the flag stays set and `irq_o` is raised again when enabled.
- R10: The summary enable register keeps only bit 3. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_evt | input | 4 | One-clock condition pulses: validity, parity, coding, lock |
| freq_code | input | 3 | Sample-rate code shown in status bits 7:5 |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; also the clear-on-read trigger |
| rd_data | output | 8 | Read data, combinational, zero when not reading |
| err_flag_o | output | 1 | Error pin, one-clock pulse per enabled hit |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench targets the moments where set and clear meet. It reads a register in the same cycle as a new event. A design that lets the clear win would lose that event, and the next read would show zero. It sends back-to-back enabled events. A design that raises the pin only on the first event, or holds it high, gives the wrong pin pattern. It turns the interrupt enable on after the flag is already set. A design that recomputes the interrupt from flag and enable would fire a spurious interrupt there. It also writes all ones to both enable registers to catch bits that should not be stored.

// File: rtl/rx_error_pkg.sv
package rx_error_pkg;
    localparam int NUM_COND   = 4;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int FREQ_W     = 3;
    localparam int FREQ_LSB   = DATA_W - FREQ_W;
    localparam int FLAG_BIT   = 3;
    localparam int IEN_BIT    = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_SUM_STAT  = 2'd0,
        REG_SUM_EN    = 2'd1,
        REG_COND_STAT = 2'd2,
        REG_COND_EN   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        FLAG_CLEAR  = 2'd0,
        FLAG_RAISED = 2'd1,
        FLAG_HELD   = 2'd2
    } flag_state_e;
endpackage

// File: rtl/rx_error_sticky.sv
module rx_error_sticky
    import rx_error_pkg::*;
#(
    parameter int WIDTH = NUM_COND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_i[i])
                    bit_q <= 1'b1;
                else if (clr_i)
                    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;

            assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q_o[i]);
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !set_i[i]) |=> !q_o[i]);
            assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o[i] && !clr_i) |=> q_o[i]);
        end
    endgenerate
endmodule

// File: rtl/rx_error_flag_fsm.sv
module rx_error_flag_fsm
    import rx_error_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FLAG_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (hit_i)
                    state_d = ien_i ? FLAG_RAISED : FLAG_HELD;
            end
            FLAG_RAISED, FLAG_HELD: begin
                if (clr_i && hit_i)
                    state_d = ien_i ? FLAG_RAISED : FLAG_HELD;
                else if (clr_i)
                    state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        irq_o  = 1'b0;
        unique case (state_q)
            FLAG_CLEAR:  begin flag_o = 1'b0; irq_o = 1'b0; end
            FLAG_RAISED: begin flag_o = 1'b1; irq_o = 1'b1; end
            FLAG_HELD:   begin flag_o = 1'b1; irq_o = 1'b0; end
            default:     begin flag_o = 1'b0; irq_o = 1'b0; end
        endcase
    end

    assert_no_repeat_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> !$rose(irq_o));
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> (!flag_o && !irq_o));
    assert_hit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_o);
    assert_irq_implies_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);
endmodule

// File: rtl/rx_error_regs.sv
module rx_error_regs
    import rx_error_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [NUM_COND-1:0] sticky_i,
    input  logic [FREQ_W-1:0]   freq_i,
    input  logic                flag_i,
    output logic [NUM_COND-1:0] cond_en_o,
    output logic                ien_o,
    output logic [DATA_W-1:0]   rd_data
);
    logic [NUM_COND-1:0] cond_en_q;
    logic                ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_en_q <= '0;
            ien_q     <= 1'b0;
        end else if (wr_en) begin
            if (addr == REG_COND_EN)
                cond_en_q <= wr_data[NUM_COND-1:0];
            if (addr == REG_SUM_EN)
                ien_q <= wr_data[IEN_BIT];
        end
    end

    assign cond_en_o = cond_en_q;
    assign ien_o     = ien_q;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_addr_e'(addr))
                REG_SUM_STAT:  rd_data[FLAG_BIT] = flag_i;
                REG_SUM_EN:    rd_data[IEN_BIT]  = ien_q;
                REG_COND_STAT: begin
                    rd_data[NUM_COND-1:0]     = sticky_i;
                    rd_data[DATA_W-1:FREQ_LSB] = freq_i;
                end
                REG_COND_EN:   rd_data[NUM_COND-1:0] = cond_en_q;
                default:       rd_data = '0;
            endcase
        end
    end

    assert_write_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_COND_EN) |=> (cond_en_o == $past(wr_data[NUM_COND-1:0])));
    assert_write_ien_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_SUM_EN) |=> (ien_o == $past(wr_data[IEN_BIT])));
endmodule

// File: rtl/rx_error_status.sv
module rx_error_status
    import rx_error_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cond_evt,
    input  logic [2:0]          freq_code,
    input  logic [1:0]          addr,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    output logic [7:0]          rd_data,
    output logic                err_flag_o,
    output logic                irq_o
);
    logic [NUM_COND-1:0] sticky;
    logic [NUM_COND-1:0] cond_en;
    logic                ien;
    logic                flag;
    logic                hit;
    logic                rd_cond;
    logic                rd_sum;
    logic                err_q;

    assign rd_cond = rd_en && (addr == REG_COND_STAT);
    assign rd_sum  = rd_en && (addr == REG_SUM_STAT);
    assign hit     = |(cond_evt & cond_en);

    rx_error_sticky #(.WIDTH(NUM_COND)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cond_evt),
        .clr_i (rd_cond),
        .q_o   (sticky)
    );

    rx_error_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .sticky_i  (sticky),
        .freq_i    (freq_code),
        .flag_i    (flag),
        .cond_en_o (cond_en),
        .ien_o     (ien),
        .rd_data   (rd_data)
    );

    rx_error_flag_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .clr_i  (rd_sum),
        .ien_i  (ien),
        .flag_o (flag),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= hit;
    end
    assign err_flag_o = err_q;

    assert_pin_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |-> $past(|(cond_evt & cond_en)));
    assert_pin_every_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cond_evt & cond_en)) |=> err_flag_o);
    assert_pin_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |-> flag);
endmodule

// File: tb/sim_rx_error_status.sv
module sim_rx_error_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_evt = '0;
    logic [2:0] freq_code = 3'b101;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       err_flag_o;
    logic       irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_error_status u0 (
        .clk(clk), .rst_n(rst_n), .cond_evt(cond_evt), .freq_code(freq_code),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .err_flag_o(err_flag_o), .irq_o(irq_o)
    );

    // {evt, wr, rd, addr, wdata, exp_rd, exp_err, exp_irq, req}
    localparam int NV = 34;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA0,1'b0,1'b0,8'd1},  // R1 clean status
        {4'h1,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd2},  // R2 validity pulse
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA1,1'b0,1'b0,8'd2},  // R2 set while masked, R6 no pin
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA0,1'b0,1'b0,8'd3},  // R3 cleared
        {4'h0,1'b1,1'b0,2'd3,8'hFF,8'h00,1'b0,1'b0,8'd5},  // R5 write mask
        {4'h0,1'b0,1'b1,2'd3,8'h00,8'h0F,1'b0,1'b0,8'd5},  // R5 upper bits zero
        {4'h0,1'b1,1'b0,2'd1,8'hFF,8'h00,1'b0,1'b0,8'd10}, // R10 write enable
        {4'h0,1'b0,1'b1,2'd1,8'h00,8'h08,1'b0,1'b0,8'd10}, // R10 only bit 3
        {4'h2,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd6},  // R6 parity
        {4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'd8},  // R8 irq rises
        {4'h4,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b1,8'd6},  // R6 single pulse
        {4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'd6},  // R6 every occurrence
        {4'h0,1'b0,1'b1,2'd0,8'h00,8'h08,1'b0,1'b1,8'd7},  // R7 flag bit 3
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA6,1'b0,1'b0,8'd9},  // R9 irq cleared
        {4'h0,1'b0,1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,8'd9},  // R9 flag cleared
        {4'h8,1'b0,1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,8'd9},  // R9 hit during read
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA8,1'b1,1'b1,8'd9},  // R9 re-raised
        {4'h8,1'b0,1'b1,2'd0,8'h00,8'h08,1'b0,1'b1,8'd9},  // R9 read with hit
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA8,1'b1,1'b1,8'd4},  // R4 lock kept
        {4'h0,1'b1,1'b0,2'd1,8'h00,8'h00,1'b0,1'b1,8'd10}, // R10 disable
        {4'h0,1'b0,1'b1,2'd0,8'h00,8'h08,1'b0,1'b1,8'd8},  // R8 irq held
        {4'h1,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd8},  // R8 hit, ien off
        {4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,8'd8},  // R8 no irq
        {4'h0,1'b1,1'b0,2'd1,8'h08,8'h00,1'b0,1'b0,8'd8},  // R8 enable late
        {4'h1,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd8},  // R8 repeat hit
        {4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,8'd8},  // R8 still no irq
        {4'h0,1'b0,1'b1,2'd0,8'h00,8'h08,1'b0,1'b0,8'd7},  // R7 flag held
        {4'h0,1'b1,1'b0,2'd3,8'h00,8'h00,1'b0,1'b0,8'd5},  // R5 mask all
        {4'h2,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd6},  // R6 masked event
        {4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,8'd6},  // R6 no pin
        {4'h0,1'b0,1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,8'd7},  // R7 masked sets no flag
        {4'h4,1'b0,1'b1,2'd2,8'h00,8'hA3,1'b0,1'b0,8'd4},  // R4 code during read
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA4,1'b0,1'b0,8'd4},  // R4 code survived
        {4'h0,1'b0,1'b1,2'd2,8'h00,8'hA0,1'b0,1'b0,8'd3}   // R3 cleared
    };

    task automatic check(input string what, input int req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] e, input logic w, input logic r,
                         input logic [1:0] a, input logic [7:0] d);
        cond_evt = e; wr_en = w; rd_en = r; addr = a; wr_data = d;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("err at reset", 1, {7'b0, err_flag_o}, 8'h00);
        check("irq at reset", 1, {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k][33:30], VEC[k][29], VEC[k][28], VEC[k][27:26], VEC[k][25:18]);
            #1;
            check($sformatf("step %0d err", k), int'(VEC[k][7:0]), {7'b0, err_flag_o}, {7'b0, VEC[k][9]});
            check($sformatf("step %0d irq", k), int'(VEC[k][7:0]), {7'b0, irq_o}, {7'b0, VEC[k][8]});
            if (VEC[k][28])
                check($sformatf("step %0d rd", k), int'(VEC[k][7:0]), rd_data, VEC[k][17:10]);
        end

        // R2: frequency code passes through to bits 7:5
        @(negedge clk);
        drive(4'h0, 1'b0, 1'b1, 2'd2, 8'h00);
        freq_code = 3'b011;
        #1;
        check("freq code", 2, rd_data, 8'h60);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        drive(4'hF, 1'b1, 1'b0, 2'd3, 8'h0F);
        @(negedge clk);
        drive(4'hF, 1'b1, 1'b0, 2'd1, 8'h08);
        @(negedge clk);
        drive(4'h0, 1'b0, 1'b0, 2'd0, 8'h00);
        #1;
        check("irq before reset", 8, {7'b0, irq_o}, 8'h01);
        rst_n = 1'b0;
        #1;
        check("irq in reset", 1, {7'b0, irq_o}, 8'h00);
        check("err in reset", 1, {7'b0, err_flag_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h0, 1'b0, 1'b1, 2'd2, 8'h00);
        #1;
        check("cond stat after reset", 1, rd_data, 8'h60);
        addr = 2'd3; #1;
        check("cond mask after reset", 1, rd_data, 8'h00);
        addr = 2'd1; #1;
        check("sum enable after reset", 1, rd_data, 8'h00);
        addr = 2'd0; #1;
        check("sum stat after reset", 1, rd_data, 8'h00);
        @(negedge clk);
        drive(4'h0, 1'b0, 1'b0, 2'd0, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule